// File: doc/BRIEF.md
# Paged Memory Window Translator

This block maps CPU memory addresses that fall in two windows of the upper memory area onto 16 KB pages of a larger physical space. Window A spans 0C0000h to 0DFFFFh and is split into eight 16 KB pages. Window B spans 0E0000h to 0EFFFFh and is split into four. Each page has its own page register. That register holds a target page number, a page enable and a target device: on-board DRAM, the DOS ROM or the BIOS ROM. When an address hits an enabled page, the block outputs the target page number followed by the low 14 address bits, together with the device. Every other address is handed on unchanged and marked for external decode. A miss never falls back to system RAM.

Software reaches the page registers through eight I/O ports whose position in I/O space can be moved. The two banks share these ports, and a control bit chooses which bank they reach. The same control register also holds a global enable for each window and the 4-bit port location. Translation requests arrive on a valid/ready stream. Results leave on a second valid/ready stream through one register stage. The upstream side may present a request on any cycle. A result that the consumer does not take stays held, and that back-pressure stops new requests from being accepted.

Top module: `paged_window_xlate`

## Requirements
- R1: After reset, the control register, every page register and rsp_valid are zero, req_ready is 1, and every request misses.
- R2: An address in 0C0000h..0DFFFFh chooses window A page register addr[16:14]. On a hit, rsp_addr equals {page number, addr[13:0]} and rsp_dev equals the device field of that register.
- R3: An address in 0E0000h..0EFFFFh chooses window B page register addr[15:14], and the mapping rule of R2 applies.
- R4: A page whose enable bit is clear does not translate.
- R5: With the global enable of a window clear, none of its pages translate, whatever their own enable bits hold.
- R6: A miss (address outside both windows, or any case of R4, R5 or R10) gives rsp_hit=0, rsp_dev=3 (external) and rsp_addr equal to the CPU address zero-extended to 24 bits.
- R7: A cfg_we pulse loads the control register, and cfg_q reads it back. Bit 0 is the window A enable, bit 1 the window B enable, bit 2 the bank select (1 = window B) and bits 7:4 the port location. Bit 3 always reads 0.
- R8: The page-register ports are the I/O addresses {8'h02, location, 1'b0, index[2:0]}. Writes to any other address change nothing. Reads of any other address, and all cycles with io_rd low, return 0 on io_rdata (combinational).
- R9: With the bank select at 0, port index i reaches window A register i. With it at 1, indexes 0..3 reach window B registers 0..3. Indexes 4..7 are then ignored for writes and read 0.
- R10: Page register format: bit 15 is the enable, bits 13:12 the device (0 DRAM, 1 DOS ROM, 2 BIOS ROM, 3 reserved, which makes the page miss) and bits 9:0 the target page number. The other bits are not stored and read 0. A read returns the stored value.
- R11: req_ready = !rsp_valid || rsp_ready. An accepted request (req_valid && req_ready) shows up on rsp_* the next cycle. A result that is not taken keeps rsp_valid high and its fields stable.
- R12: A request is translated with the register contents that were in place before the clock edge that accepts it. A register write on that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_q | output | 8 | Control register contents |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when valid |
| req_addr | input | 20 | CPU memory address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 24 | Translated or passed-through address |
| rsp_dev | output | 2 | Target device (0 DRAM, 1 DOS ROM, 2 BIOS ROM, 3 external) |
| rsp_hit | output | 1 | Address was translated |

## Verification
A behavioural model in the bench keeps its own copy of the registers and of the result slot, and is compared with the design on every cycle. Directed steps come first. They check the reset state, and then they check that moving the port location makes the old ports inert and that bank-B writes to indexes 4..7 leave window B unchanged. They also cover a page write on the same edge as a request, which separates old-mapping from new-mapping behaviour. A long random phase follows. Addresses are mostly inside the windows, with the exact edges 0BFFFFh, 0C0000h, 0DFFFFh, 0E0000h, 0EFFFFh and 0F0000h mixed in, which exposes a wrong window decode or page index. Port addresses mostly hit the aperture, so bank and location errors show up. The consumer stalls at random, so a result that is dropped or altered under back-pressure gets caught.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  localparam int CPU_AW   = 20;
  localparam int PAGE_SH  = 14;
  localparam int PHYS_AW  = 24;
  localparam int PG_W     = PHYS_AW - PAGE_SH;
  localparam int IO_AW    = 16;
  localparam int IO_DW    = 16;
  localparam int A_PAGES  = 8;
  localparam int B_PAGES  = 4;
  localparam int A_IW     = $clog2(A_PAGES);
  localparam int B_IW     = $clog2(B_PAGES);
  localparam int A_TAG_W  = CPU_AW - PAGE_SH - A_IW;
  localparam int B_TAG_W  = CPU_AW - PAGE_SH - B_IW;
  localparam logic [A_TAG_W-1:0] A_TAG = 3'b110;
  localparam logic [B_TAG_W-1:0] B_TAG = 4'hE;

  typedef enum logic [1:0] {
    DEV_DRAM = 2'd0,
    DEV_DOS  = 2'd1,
    DEV_BIOS = 2'd2,
    DEV_EXT  = 2'd3
  } dev_e;

  typedef struct packed {
    logic            en;
    dev_e            dev;
    logic [PG_W-1:0] pg;
  } page_t;

  function automatic page_t word_to_page(input logic [IO_DW-1:0] w);
    page_t p;
    p.en  = w[15];
    p.dev = dev_e'(w[13:12]);
    p.pg  = w[PG_W-1:0];
    return p;
  endfunction

  function automatic logic [IO_DW-1:0] page_to_word(input page_t p);
    return {p.en, 1'b0, p.dev, 2'b00, p.pg};
  endfunction
endpackage

// File: rtl/pwx_page_bank.sv
module pwx_page_bank
  import pwx_pkg::*;
#(
  parameter int NPAGES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NPAGES)-1:0]  wr_idx,
  input  page_t                      wr_data,
  output page_t [NPAGES-1:0]         pages
);
  localparam int IW = $clog2(NPAGES);

  page_t regs_q [NPAGES];

  for (genvar g = 0; g < NPAGES; g++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))
        regs_q[g] <= wr_data;
    end
    assign pages[g] = regs_q[g];
  end
endmodule

// File: rtl/pwx_io_regs.sv
module pwx_io_regs
  import pwx_pkg::*;
#(
  parameter logic [IO_AW-9:0] IO_PAGE_HI = 8'h02
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [7:0]            cfg_wdata,
  output logic [7:0]            cfg_q,
  input  logic                  io_wr,
  input  logic                  io_rd,
  input  logic [IO_AW-1:0]      io_addr,
  input  logic [IO_DW-1:0]      io_wdata,
  output logic [IO_DW-1:0]      io_rdata,
  output logic                  win_a_en,
  output logic                  win_b_en,
  output page_t [A_PAGES-1:0]   pages_a,
  output page_t [B_PAGES-1:0]   pages_b
);
  logic       bank_b_q;
  logic [3:0] io_loc_q;
  logic       en_a_q, en_b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_a_q   <= 1'b0;
      en_b_q   <= 1'b0;
      bank_b_q <= 1'b0;
      io_loc_q <= '0;
    end else if (cfg_we) begin
      en_a_q   <= cfg_wdata[0];
      en_b_q   <= cfg_wdata[1];
      bank_b_q <= cfg_wdata[2];
      io_loc_q <= cfg_wdata[7:4];
    end
  end

  assign cfg_q    = {io_loc_q, 1'b0, bank_b_q, en_b_q, en_a_q};
  assign win_a_en = en_a_q;
  assign win_b_en = en_b_q;

  logic            ap_hit;
  logic [A_IW-1:0] port_idx;
  logic            idx_in_b;
  page_t           wr_page;
  page_t           rd_page;

  assign ap_hit   = (io_addr[IO_AW-1:8] == IO_PAGE_HI) &&
                    (io_addr[7:4] == io_loc_q) && !io_addr[3];
  assign port_idx = io_addr[A_IW-1:0];
  assign idx_in_b = port_idx < A_IW'(B_PAGES);
  assign wr_page  = word_to_page(io_wdata);

  pwx_page_bank #(.NPAGES(A_PAGES)) u_bank_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (io_wr && ap_hit && !bank_b_q),
    .wr_idx  (port_idx),
    .wr_data (wr_page),
    .pages   (pages_a)
  );

  pwx_page_bank #(.NPAGES(B_PAGES)) u_bank_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (io_wr && ap_hit && bank_b_q && idx_in_b),
    .wr_idx  (port_idx[B_IW-1:0]),
    .wr_data (wr_page),
    .pages   (pages_b)
  );

  always_comb begin
    if (!bank_b_q)
      rd_page = pages_a[port_idx];
    else if (idx_in_b)
      rd_page = pages_b[port_idx[B_IW-1:0]];
    else
      rd_page = '0;
  end

  assign io_rdata = (io_rd && ap_hit) ? page_to_word(rd_page) : '0;

  AST_B_UPPER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && ap_hit && bank_b_q && !idx_in_b) |=> $stable(pages_b)); // R9

  AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == ($past(cfg_wdata) & 8'hF7))); // R7

  AST_BANK_A_QUIET_IN_B: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_b_q && !cfg_we) |=> $stable(pages_a)); // R9
endmodule

// File: rtl/pwx_lookup.sv
module pwx_lookup
  import pwx_pkg::*;
(
  input  logic [CPU_AW-1:0]    cpu_addr,
  input  logic                 win_a_en,
  input  logic                 win_b_en,
  input  page_t [A_PAGES-1:0]  pages_a,
  input  page_t [B_PAGES-1:0]  pages_b,
  output logic                 hit,
  output dev_e                 dev,
  output logic [PHYS_AW-1:0]   phys
);
  logic  in_a, in_b, win_on;
  page_t sel;

  assign in_a = cpu_addr[CPU_AW-1:PAGE_SH+A_IW] == A_TAG;
  assign in_b = cpu_addr[CPU_AW-1:PAGE_SH+B_IW] == B_TAG;

  always_comb begin
    if (in_a) begin
      sel    = pages_a[cpu_addr[PAGE_SH+A_IW-1:PAGE_SH]];
      win_on = win_a_en;
    end else if (in_b) begin
      sel    = pages_b[cpu_addr[PAGE_SH+B_IW-1:PAGE_SH]];
      win_on = win_b_en;
    end else begin
      sel    = '0;
      win_on = 1'b0;
    end
  end

  assign hit  = win_on && sel.en && (sel.dev != DEV_EXT);
  assign dev  = hit ? sel.dev : DEV_EXT;
  assign phys = hit ? {sel.pg, cpu_addr[PAGE_SH-1:0]} : PHYS_AW'(cpu_addr);
endmodule

// File: rtl/pwx_rsp_reg.sv
module pwx_rsp_reg
  import pwx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                in_hit,
  input  dev_e                in_dev,
  input  logic [PHYS_AW-1:0]  in_phys,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_hit,
  output dev_e                rsp_dev,
  output logic [PHYS_AW-1:0]  rsp_addr
);
  logic fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_dev   <= DEV_EXT;
      rsp_addr  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= in_hit;
      rsp_dev   <= in_dev;
      rsp_addr  <= in_phys;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
                                   $stable(rsp_hit) && $stable(rsp_dev))); // R11

  AST_ACCEPT_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R11
endmodule

// File: rtl/paged_window_xlate.sv
module paged_window_xlate
  import pwx_pkg::*;
#(
  parameter logic [7:0] IO_PAGE_HI = 8'h02
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_q,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic [IO_DW-1:0]    io_wdata,
  output logic [IO_DW-1:0]    io_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CPU_AW-1:0]   req_addr,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [PHYS_AW-1:0]  rsp_addr,
  output logic [1:0]          rsp_dev,
  output logic                rsp_hit
);
  logic                 win_a_en, win_b_en;
  page_t [A_PAGES-1:0]  pages_a;
  page_t [B_PAGES-1:0]  pages_b;
  logic                 lk_hit;
  dev_e                 lk_dev;
  logic [PHYS_AW-1:0]   lk_phys;
  dev_e                 out_dev;

  pwx_io_regs #(.IO_PAGE_HI(IO_PAGE_HI)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .win_a_en  (win_a_en),
    .win_b_en  (win_b_en),
    .pages_a   (pages_a),
    .pages_b   (pages_b)
  );

  pwx_lookup u_lookup (
    .cpu_addr (req_addr),
    .win_a_en (win_a_en),
    .win_b_en (win_b_en),
    .pages_a  (pages_a),
    .pages_b  (pages_b),
    .hit      (lk_hit),
    .dev      (lk_dev),
    .phys     (lk_phys)
  );

  pwx_rsp_reg u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .in_hit    (lk_hit),
    .in_dev    (lk_dev),
    .in_phys   (lk_phys),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hit   (rsp_hit),
    .rsp_dev   (out_dev),
    .rsp_addr  (rsp_addr)
  );

  assign rsp_dev = out_dev;

  AST_WINDOW_A_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_addr[19:17] == 3'b110) && !win_a_en)
      |=> !rsp_hit); // R5

  AST_MISS_IS_EXTERNAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_dev == 2'd3)); // R6

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lk_hit)
      |=> (rsp_hit && rsp_addr[13:0] == $past(req_addr[13:0]))); // R2
endmodule

// File: tb/tb_paged_window_xlate.sv
module tb_paged_window_xlate;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_q;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0;
  logic [15:0] io_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [23:0] rsp_addr;
  logic [1:0]  rsp_dev;
  logic        rsp_hit;

  always #(CLK_P/2) clk = ~clk;

  paged_window_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_dev(rsp_dev), .rsp_hit(rsp_hit)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  // reference state
  logic [15:0] pa [8];
  logic [15:0] pb [4];
  logic [7:0]  ctl;
  logic        m_rv;
  logic [23:0] m_addr;
  logic [1:0]  m_dev;
  logic        m_hit;
  string       m_tag;
  string       force_tag = "";

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string tag, input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_xlate(input logic [19:0] a, output logic hit,
                             output logic [1:0] dev, output logic [23:0] pa_out,
                             output string tag);
    logic [15:0] r;
    logic        gen;
    int          base;
    hit = 0; r = '0; gen = 0; tag = "R6";
    if (a >= 20'hC0000 && a <= 20'hDFFFF) begin
      base = (int'(a) - 'hC0000) / 16384;
      r = pa[base]; gen = ctl[0]; tag = "R2";
    end else if (a >= 20'hE0000 && a <= 20'hEFFFF) begin
      base = (int'(a) - 'hE0000) / 16384;
      r = pb[base]; gen = ctl[1]; tag = "R3";
    end
    if (tag != "R6") begin
      if (!gen) tag = "R5";
      else if (!r[15]) tag = "R4";
      else if (r[13:12] == 2'd3) tag = "R10";
      else hit = 1;
    end
    if (hit) begin
      dev = r[13:12];
      pa_out = 24'(int'(r[9:0]) * 16384 + int'(a) % 16384);
    end else begin
      dev = 2'd3;
      pa_out = {4'h0, a};
    end
  endtask

  function automatic bit ap_match();
    return io_addr[15:8] == 8'h02 && io_addr[7:4] == ctl[7:4] && !io_addr[3];
  endfunction

  task automatic tick();
    logic        exp_ready, h;
    logic [1:0]  d;
    logic [23:0] p;
    logic [15:0] exp_rd;
    int          idx;
    string       t, rt;
    #1;
    exp_ready = !m_rv || rsp_ready;
    chk(32'(req_ready), 32'(exp_ready), "R11", "req_ready");
    idx = int'(io_addr[2:0]);
    exp_rd = '0;
    rt = "R8";
    if (io_rd && ap_match()) begin
      if (!ctl[2]) begin exp_rd = pa[idx]; rt = "R10"; end
      else begin rt = "R9"; if (idx < 4) exp_rd = pb[idx]; end
    end
    if (force_tag != "") rt = force_tag;
    chk(32'(io_rdata), 32'(exp_rd), rt, "io_rdata");
    // state updates as the coming edge will apply them
    if (req_valid && exp_ready) begin
      model_xlate(req_addr, h, d, p, t);
      m_rv = 1; m_hit = h; m_dev = d; m_addr = p;
      m_tag = (force_tag != "") ? force_tag : t;
    end else if (rsp_ready) begin
      m_rv = 0;
    end
    if (io_wr && ap_match()) begin
      if (!ctl[2]) pa[idx] = io_wdata & 16'hB3FF;
      else if (idx < 4) pb[idx] = io_wdata & 16'hB3FF;
    end
    if (cfg_we) ctl = cfg_wdata & 8'hF7;
    @(posedge clk);
    @(negedge clk);
    chk(32'(rsp_valid), 32'(m_rv), "R11", "rsp_valid");
    chk(32'(cfg_q), 32'(ctl), (force_tag != "") ? force_tag : "R7", "cfg_q");
    if (m_rv) begin
      chk(32'(rsp_hit),  32'(m_hit),  m_tag, "rsp_hit");
      chk(32'(rsp_dev),  32'(m_dev),  m_tag, "rsp_dev");
      chk(32'(rsp_addr), 32'(m_addr), m_tag, "rsp_addr");
    end
  endtask

  task automatic idle();
    cfg_we = 0; io_wr = 0; io_rd = 0; req_valid = 0;
  endtask

  task automatic cfg_write(input logic [7:0] v);
    idle(); cfg_we = 1; cfg_wdata = v; tick(); idle();
  endtask

  task automatic io_write(input logic [15:0] a, input logic [15:0] v);
    idle(); io_wr = 1; io_addr = a; io_wdata = v; tick(); idle();
  endtask

  task automatic io_read(input logic [15:0] a);
    idle(); io_rd = 1; io_addr = a; tick(); idle();
  endtask

  task automatic request(input logic [19:0] a);
    idle(); rsp_ready = 1; req_valid = 1; req_addr = a; tick(); idle();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) pa[i] = '0;
    for (int i = 0; i < 4; i++) pb[i] = '0;
    ctl = '0; m_rv = 0; m_addr = '0; m_dev = 2'd3; m_hit = 0; m_tag = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state seen at the ports
    chk(32'(cfg_q), 0, "R1", "cfg_q after reset");
    chk(32'(rsp_valid), 0, "R1", "rsp_valid after reset");
    chk(32'(req_ready), 1, "R1", "req_ready after reset");
    force_tag = "R1";
    for (int i = 0; i < 8; i++) io_read(16'h0200 + 16'(i));
    request(20'hC4000);
    request(20'hE8000);
    force_tag = "";

    // program window A through location 0, bank A
    for (int i = 0; i < 8; i++)
      io_write(16'h0200 + 16'(i), 16'h8000 | (16'(i % 3) << 12) | 16'(10 * i + 1));
    cfg_write(8'h01);
    request(20'hC0000);
    request(20'hDFFFF);
    request(20'hC7ABC);
    // R8: move ports to location 5; old location now inert
    cfg_write(8'h51);
    io_write(16'h0203, 16'h8FFF);
    io_read(16'h0203);
    io_read(16'h0253);
    io_write(16'h025B, 16'h8123);
    io_read(16'h0253);
    // R9: bank B, upper indexes ignored
    cfg_write(8'h57);
    io_write(16'h0250, 16'hA155);
    io_write(16'h0253, 16'h9002);
    io_write(16'h0256, 16'hFFFF);
    io_read(16'h0256);
    io_read(16'h0250);
    cfg_write(8'h53);
    request(20'hE0010);
    request(20'hEC123);
    request(20'hF0000);
    // R4: page enable clear
    cfg_write(8'h57);
    io_write(16'h0250, 16'h2155);
    cfg_write(8'h53);
    request(20'hE0010);
    // R10: reserved device code
    io_write(16'h0251, 16'hB3FF);
    io_read(16'h0251);
    request(20'hC4000);
    // R12: write on the same edge as the accepting edge
    idle(); force_tag = "R12";
    rsp_ready = 1; req_valid = 1; req_addr = 20'hC0123;
    io_wr = 1; io_addr = 16'h0250; io_wdata = 16'h9077;
    tick(); idle();
    request(20'hC0123);
    force_tag = "";

    // random mixed traffic
    for (int c = 0; c < 4000; c++) begin
      int r;
      idle();
      rsp_ready = ($urandom % 4) != 0;
      req_valid = ($urandom % 3) != 0;
      r = $urandom % 8;
      if (r < 4) req_addr = 20'hC0000 + 20'($urandom % 'h20000);
      else if (r < 6) req_addr = 20'hE0000 + 20'($urandom % 'h10000);
      else if (r == 6) req_addr = 20'($urandom);
      else begin
        case ($urandom % 6)
          0: req_addr = 20'hBFFFF;
          1: req_addr = 20'hC0000;
          2: req_addr = 20'hDFFFF;
          3: req_addr = 20'hE0000;
          4: req_addr = 20'hEFFFF;
          default: req_addr = 20'hF0000;
        endcase
      end
      io_wr = ($urandom % 4) == 0;
      io_rd = ($urandom % 4) == 0;
      io_addr[15:8] = (($urandom % 8) != 0) ? 8'h02 : 8'($urandom);
      io_addr[7:4]  = (($urandom % 8) != 0) ? ctl[7:4] : 4'($urandom);
      io_addr[3]    = ($urandom % 8) == 0;
      io_addr[2:0]  = 3'($urandom);
      io_wdata = 16'($urandom);
      if (($urandom % 32) == 0) begin
        cfg_we = 1;
        cfg_wdata = {(($urandom % 2) != 0) ? 4'h5 : 4'h0, 1'($urandom),
                     1'($urandom), (($urandom % 4) != 0) ? 2'b11 : 2'($urandom)};
      end
      tick();
    end
    idle();
    rsp_ready = 1;
    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule